// File: doc/BRIEF.md
# DDR2 Request Scheduler with Open-Bank Table

This block is the command front end of a memory controller for registered DDR2 modules. User Read and Write requests, each moving one 36-byte block, are queued in a command FIFO. The scheduler then turns the request at the head of the queue into DRAM commands. An associative table remembers which banks hold an open row and which row that is. With this table the controller can keep rows open in many banks at once, so a request that hits an open row needs only its column command.

For each head request the scheduler picks one of four paths: column command only (row hit), precharge-activate-column (different row open in that bank), activate-column (bank closed, free table slot), or precharge of the oldest open bank followed by activate-column (bank closed, table full). One central spacing timer enforces the minimum gap after every command. A free-running interval timer requests refresh every 7.8 us (1560 cycles of the 5 ns command clock). Once the request in progress completes, refresh wins over the queue: the block precharges every bank, empties the table and issues the refresh. Column commands wait for the data path's ready signal and announce themselves on a transfer strobe.

Top module: `ddr_req_sched`

## Requirements
- R1: A request is 30 bits (write flag, rank, 3-bit bank, 14-bit row, 11-bit column). The queue holds FIFO_DEPTH (64) of them in arrival order. req_full is high when it holds FIFO_DEPTH entries, and a push while req_full is high is discarded. Every accepted request produces exactly one column command.
- R2: Command codes on cmd_code are NOP=0, ACT=1, RD=2, WR=3, PRE=4, PREA=5, REF=6, valid only while cmd_valid is high. ACT carries the row on cmd_addr. RD/WR carry the column zero-extended. PRE carries the target rank/bank with address 0. PREA and REF address both ranks and drive rank, bank and address as 0.
- R3: A request whose rank, bank and row match an open table entry issues only its RD or WR command.
- R4: A request to an open bank with a different row issues PRE to that bank, then ACT with the new row, then its column command. The table entry keeps its slot and takes the new row.
- R5: A request to a bank absent from the table, while a slot is free, issues ACT then its column command, and the bank takes the next slot in allocation order. A bank appears at most once in the table.
- R6: A request to an absent bank while all TBL_ENTRIES slots are in use first issues PRE to the bank allocated earliest. That slot is then reused for the new bank, and slots are reused in allocation order.
- R7: The gap from a command to the next one is at least T_RP cycles after PRE or PREA, T_RCD after ACT, T_CCD after RD/WR and T_RFC after REF. Each of these is at least 2.
- R8: RD/WR is issued only in a cycle where xfer_ready is high. xfer_go is high exactly in the cycles of RD/WR commands, with xfer_wr high for WR.
- R9: Every REFI_CYC cycles a refresh becomes due. After the request in progress completes, and ahead of any queued request, PREA is issued and the table is emptied, then REF.
- R10: After reset, cmd_valid, xfer_go and req_full are low and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_push | input | 1 | Push one request into the queue |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_rank | input | 1 | Module/rank select |
| req_bank | input | 3 | Bank address |
| req_row | input | 14 | Row address |
| req_col | input | 11 | Column address |
| req_full | output | 1 | Queue full, push is ignored |
| xfer_ready | input | 1 | Data path can take a column transfer |
| cmd_valid | output | 1 | A DRAM command is issued this cycle |
| cmd_code | output | 3 | Command code (see R2) |
| cmd_rank | output | 1 | Rank of the command |
| cmd_bank | output | 3 | Bank of the command |
| cmd_addr | output | 14 | Row or column address |
| xfer_go | output | 1 | Column command issued, data path starts |
| xfer_wr | output | 1 | The transfer is a write |

## Verification
The hardest case to reach is eviction. The rank and bank fields name only 16 banks, so a table of 16 entries never overflows. The bench therefore builds the block with a four-entry table and cycles through five or more banks, which forces precharges of the earliest-opened bank. It also drives many requests from a small set of banks and rows with a stuttering ready signal, so that refreshes land between queued requests. A reference model inside the monitor predicts each command sequence at the moment the sequence starts, so a refresh that empties the table is taken into account.

// File: rtl/ddr_sched_pkg.sv
`timescale 1ns/1ps
package ddr_sched_pkg;
  localparam int RANK_W = 1;
  localparam int BANK_W = 3;
  localparam int ROW_W  = 14;
  localparam int COL_W  = 11;
  localparam int KEY_W  = RANK_W + BANK_W;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6
  } dram_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_ACT, ST_COL, ST_PREA, ST_REF
  } sched_st_e;

  typedef struct packed {
    logic              wr;
    logic [RANK_W-1:0] rank;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
  } req_t;

  // minimum cycles from a command to the next one
  function automatic int unsigned cmd_gap(dram_cmd_e c, int unsigned t_rp,
                                          int unsigned t_rcd, int unsigned t_ccd,
                                          int unsigned t_rfc);
    case (c)
      CMD_PRE, CMD_PREA: return t_rp;
      CMD_ACT:           return t_rcd;
      CMD_RD, CMD_WR:    return t_ccd;
      CMD_REF:           return t_rfc;
      default:           return 1;
    endcase
  endfunction

  function automatic logic [KEY_W-1:0] req_key(req_t r);
    return {r.rank, r.bank};
  endfunction
endpackage

// File: rtl/sched_cmd_fifo.sv
`timescale 1ns/1ps
module sched_cmd_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wptr, rptr;
  logic             push_ok, pop_ok;

  assign empty   = (wptr == rptr);
  assign full    = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full && $stable(rptr)) else $error("push into full queue"); // R1
  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty) else $error("pop from empty queue"); // R1
endmodule

// File: rtl/sched_bank_table.sv
`timescale 1ns/1ps
module sched_bank_table #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 4,
  parameter int ROW_W   = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] look_key,
  input  logic [ROW_W-1:0] look_row,
  output logic             hit,
  output logic             row_hit,
  output logic             full,
  output logic             any_valid,
  output logic [KEY_W-1:0] victim_key,
  input  logic             wr_en,
  input  logic             clr_all
);
  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld;
  logic [KEY_W-1:0]   key_r [ENTRIES];
  logic [ROW_W-1:0]   row_r [ENTRIES];
  logic [ENTRIES-1:0] key_match, row_match;
  logic [IW-1:0]      ptr;
  logic               full_r;
  logic               alloc;

  assign alloc = wr_en && !hit;

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      assign key_match[e] = vld[e] && (key_r[e] == look_key);
      assign row_match[e] = key_match[e] && (row_r[e] == look_row);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld[e]   <= 1'b0;
          key_r[e] <= '0;
          row_r[e] <= '0;
        end else if (clr_all) begin
          vld[e] <= 1'b0;
        end else if (wr_en && key_match[e]) begin
          row_r[e] <= look_row;
        end else if (alloc && ptr == IW'(e)) begin
          vld[e]   <= 1'b1;
          key_r[e] <= look_key;
          row_r[e] <= look_row;
        end
      end
    end
  endgenerate

  assign hit        = |key_match;
  assign row_hit    = |row_match;
  assign any_valid  = |vld;
  assign full       = full_r;
  assign victim_key = key_r[ptr];

  // slots are taken in circular order, so ptr always names the oldest slot once full
  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) begin
      ptr    <= '0;
      full_r <= 1'b0;
    end else if (alloc) begin
      ptr    <= (ptr == IW'(ENTRIES-1)) ? '0 : ptr + 1'b1;
      full_r <= full_r || (ptr == IW'(ENTRIES-1));
    end
  end

  AST_KEY_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(key_match)) else $error("bank held twice"); // R5
  AST_NO_ALLOC_WHEN_FULL_UNSAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && full_r) |-> vld[ptr]) else $error("full table with empty victim"); // R6
endmodule

// File: rtl/sched_timers.sv
`timescale 1ns/1ps
module sched_timers
  import ddr_sched_pkg::*;
#(
  parameter int T_RP     = 3,
  parameter int T_RCD    = 3,
  parameter int T_CCD    = 2,
  parameter int T_RFC    = 26,
  parameter int REFI_CYC = 1560
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      issue,
  input  dram_cmd_e issue_code,
  input  logic      ref_ack,
  output logic      gap_ok,
  output logic      ref_due
);
  localparam int GAP_A   = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int GAP_B   = (T_CCD > T_RFC) ? T_CCD : T_RFC;
  localparam int GAP_MAX = (GAP_A > GAP_B) ? GAP_A : GAP_B;
  localparam int GW      = $clog2(GAP_MAX + 1);
  localparam int RW      = $clog2(REFI_CYC);

  logic [GW-1:0] gap_cnt;
  logic [RW-1:0] refi_cnt;
  logic          refi_wrap;

  assign gap_ok    = (gap_cnt == '0);
  assign refi_wrap = (refi_cnt == RW'(REFI_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= '0;
    end else if (issue) begin
      gap_cnt <= GW'(cmd_gap(issue_code, T_RP, T_RCD, T_CCD, T_RFC) - 1);
    end else if (!gap_ok) begin
      gap_cnt <= gap_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refi_cnt <= '0;
      ref_due  <= 1'b0;
    end else begin
      refi_cnt <= refi_wrap ? '0 : refi_cnt + 1'b1;
      if (refi_wrap)    ref_due <= 1'b1;
      else if (ref_ack) ref_due <= 1'b0;
    end
  end

  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !gap_ok) else $error("spacing window not opened"); // R7
  AST_REF_DUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_due && !ref_ack) |=> ref_due) else $error("refresh request lost"); // R9
endmodule

// File: rtl/ddr_req_sched.sv
`timescale 1ns/1ps
module ddr_req_sched
  import ddr_sched_pkg::*;
#(
  parameter int FIFO_DEPTH  = 64,
  parameter int TBL_ENTRIES = 16,
  parameter int T_RP        = 3,
  parameter int T_RCD       = 3,
  parameter int T_CCD       = 2,
  parameter int T_RFC       = 26,
  parameter int REFI_CYC    = 1560
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_push,
  input  logic              req_wr,
  input  logic [RANK_W-1:0] req_rank,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_full,
  input  logic              xfer_ready,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic [RANK_W-1:0] cmd_rank,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_addr,
  output logic              xfer_go,
  output logic              xfer_wr
);
  localparam int REQ_W = $bits(req_t);

  sched_st_e        st;
  req_t             head;
  logic [REQ_W-1:0] q_dout;
  logic             q_empty, q_pop;
  logic [KEY_W-1:0] head_key, pre_key, victim_key, cmd_key;
  logic             tbl_hit, tbl_row_hit, tbl_full, tbl_any;
  logic             gap_ok, ref_due;
  dram_cmd_e        cmd_e;

  // named issue events
  logic issue_pre, issue_act, issue_col, issue_prea, issue_ref;

  sched_cmd_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(REQ_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(req_push), .din({req_wr, req_rank, req_bank, req_row, req_col}),
    .pop(q_pop), .dout(q_dout), .empty(q_empty), .full(req_full)
  );

  assign head     = req_t'(q_dout);
  assign head_key = req_key(head);

  sched_bank_table #(.ENTRIES(TBL_ENTRIES), .KEY_W(KEY_W), .ROW_W(ROW_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .look_key(head_key), .look_row(head.row),
    .hit(tbl_hit), .row_hit(tbl_row_hit), .full(tbl_full), .any_valid(tbl_any),
    .victim_key(victim_key), .wr_en(issue_act), .clr_all(issue_prea)
  );

  sched_timers #(.T_RP(T_RP), .T_RCD(T_RCD), .T_CCD(T_CCD), .T_RFC(T_RFC),
                 .REFI_CYC(REFI_CYC)) u_tim (
    .clk(clk), .rst_n(rst_n),
    .issue(cmd_valid), .issue_code(cmd_e), .ref_ack(issue_ref),
    .gap_ok(gap_ok), .ref_due(ref_due)
  );

  assign issue_pre  = (st == ST_PRE)  && gap_ok;
  assign issue_act  = (st == ST_ACT)  && gap_ok;
  assign issue_col  = (st == ST_COL)  && gap_ok && xfer_ready;
  assign issue_prea = (st == ST_PREA) && gap_ok;
  assign issue_ref  = (st == ST_REF)  && gap_ok;
  assign q_pop      = issue_col;

  always_comb begin
    cmd_e    = CMD_NOP;
    cmd_key  = '0;
    cmd_addr = '0;
    if (issue_pre) begin
      cmd_e   = CMD_PRE;
      cmd_key = pre_key;
    end else if (issue_act) begin
      cmd_e    = CMD_ACT;
      cmd_key  = head_key;
      cmd_addr = head.row;
    end else if (issue_col) begin
      cmd_e    = head.wr ? CMD_WR : CMD_RD;
      cmd_key  = head_key;
      cmd_addr = ROW_W'(head.col);
    end else if (issue_prea) begin
      cmd_e = CMD_PREA;
    end else if (issue_ref) begin
      cmd_e = CMD_REF;
    end
  end

  assign cmd_valid            = (cmd_e != CMD_NOP);
  assign cmd_code             = cmd_e;
  assign {cmd_rank, cmd_bank} = cmd_key;
  assign xfer_go              = issue_col;
  assign xfer_wr              = issue_col && head.wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      pre_key <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (ref_due) begin
            st <= ST_PREA;
          end else if (!q_empty) begin
            if (tbl_row_hit) begin
              st <= ST_COL;
            end else if (tbl_hit) begin
              pre_key <= head_key;
              st      <= ST_PRE;
            end else if (tbl_full) begin
              pre_key <= victim_key;
              st      <= ST_PRE;
            end else begin
              st <= ST_ACT;
            end
          end
        end
        ST_PRE:  if (issue_pre)  st <= ST_ACT;
        ST_ACT:  if (issue_act)  st <= ST_COL;
        ST_COL:  if (issue_col)  st <= ST_IDLE;
        ST_PREA: if (issue_prea) st <= ST_REF;
        ST_REF:  if (issue_ref)  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_COL_ON_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    issue_col |-> tbl_row_hit) else $error("column to a closed row"); // R3
  AST_ACT_NOT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    issue_act |-> !tbl_row_hit) else $error("activate of an open row"); // R4
  AST_EVICT_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_pre && pre_key != head_key) |-> tbl_full) else $error("eviction with free slot"); // R6
  AST_CMD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid) else $error("back-to-back commands"); // R7
  AST_COL_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |-> xfer_ready && (cmd_e == CMD_RD || cmd_e == CMD_WR)) else $error("transfer without ready"); // R8
  AST_REF_TABLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ref |-> !tbl_any) else $error("refresh with open banks"); // R9
endmodule

// File: tb/tb_ddr_req_sched.sv
`timescale 1ns/1ps
module tb_ddr_req_sched;
  import ddr_sched_pkg::*;

  localparam int TBL = 4, RP = 3, RCD = 3, CCD = 2, RFC = 26, REFI = 1560, DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_push = 0, req_wr = 0, xfer_ready = 1;
  logic [0:0] req_rank = '0;
  logic [2:0] req_bank = '0;
  logic [13:0] req_row = '0;
  logic [10:0] req_col = '0;
  logic req_full, cmd_valid, xfer_go, xfer_wr;
  logic [2:0] cmd_code, cmd_bank;
  logic [0:0] cmd_rank;
  logic [13:0] cmd_addr;

  always #2 clk = ~clk;

  ddr_req_sched #(.FIFO_DEPTH(DEPTH), .TBL_ENTRIES(TBL), .T_RP(RP), .T_RCD(RCD),
                  .T_CCD(CCD), .T_RFC(RFC), .REFI_CYC(REFI)) dut (
    .clk(clk), .rst_n(rst_n), .req_push(req_push), .req_wr(req_wr),
    .req_rank(req_rank), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_full(req_full), .xfer_ready(xfer_ready), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_rank(cmd_rank), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .xfer_go(xfer_go), .xfer_wr(xfer_wr)
  );

  typedef struct {
    logic [2:0]  code;
    logic [3:0]  key;
    logic [13:0] addr;
    string       tag;
  } exp_t;

  req_t req_q[$];
  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0, n_drop = 0, n_acc = 0, n_col = 0, n_ref = 0;
  int n_evict = 0, n_conf = 0, n_hit = 0;
  longint cyc = 0, last_cyc = 0;
  logic [2:0] last_code = 3'd0;
  bit have_last = 0, rand_phase = 0, done = 0;
  bit m_vld [TBL];
  logic [3:0] m_key [TBL];
  logic [13:0] m_row [TBL];
  int m_ptr = 0;
  bit m_full = 0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int gap_of(logic [2:0] c);
    case (c)
      3'd4, 3'd5: return RP;
      3'd1:       return RCD;
      3'd2, 3'd3: return CCD;
      3'd6:       return RFC;
      default:    return 1;
    endcase
  endfunction

  function automatic exp_t mk(logic [2:0] c, logic [3:0] k, logic [13:0] a, string t);
    exp_t e;
    e.code = c; e.key = k; e.addr = a; e.tag = t;
    return e;
  endfunction

  // reference model: expand one request into its command list
  task automatic expand(req_t r);
    logic [3:0] k = {r.rank, r.bank};
    int h = -1;
    for (int i = 0; i < TBL; i++) if (m_vld[i] && m_key[i] == k) h = i;
    if (h >= 0 && m_row[h] == r.row) begin
      n_hit++;
    end else if (h >= 0) begin
      n_conf++;
      exp_q.push_back(mk(3'd4, k, 14'd0, "R4"));
      exp_q.push_back(mk(3'd1, k, r.row, "R4"));
      m_row[h] = r.row;
    end else begin
      if (m_full) begin
        n_evict++;
        exp_q.push_back(mk(3'd4, m_key[m_ptr], 14'd0, "R6"));
      end
      exp_q.push_back(mk(3'd1, k, r.row, "R5"));
      m_vld[m_ptr] = 1; m_key[m_ptr] = k; m_row[m_ptr] = r.row;
      if (m_ptr == TBL - 1) begin m_ptr = 0; m_full = 1; end
      else m_ptr++;
    end
    exp_q.push_back(mk(r.wr ? 3'd3 : 3'd2, k, 14'(r.col), "R3"));
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && !done) begin
        if (cmd_valid) begin
          exp_t e;
          if (have_last)
            check((cyc - last_cyc) >= gap_of(last_code), "R7", "command gap",
                  cyc - last_cyc, gap_of(last_code));
          have_last = 1; last_cyc = cyc; last_code = cmd_code;
          if (exp_q.size() == 0) begin
            if (cmd_code == 3'd5) begin
              n_ref++;
              check(cyc >= longint'(n_ref) * REFI - 2 && cyc <= longint'(n_ref) * REFI + 300,
                    "R9", "refresh cycle", cyc, longint'(n_ref) * REFI);
              for (int i = 0; i < TBL; i++) m_vld[i] = 0;
              m_ptr = 0; m_full = 0;
              exp_q.push_back(mk(3'd5, 4'd0, 14'd0, "R9"));
              exp_q.push_back(mk(3'd6, 4'd0, 14'd0, "R9"));
            end else if (req_q.size() == 0) begin
              check(0, "R1", "command with no request", cmd_code, 0);
            end else begin
              expand(req_q.pop_front());
            end
          end
          if (exp_q.size() != 0) begin
            e = exp_q.pop_front();
            check(cmd_code == e.code, e.tag, "cmd_code", cmd_code, e.code);
            check({cmd_rank, cmd_bank} == e.key, "R2", "rank/bank", {cmd_rank, cmd_bank}, e.key);
            check(cmd_addr == e.addr, "R2", "cmd_addr", cmd_addr, e.addr);
          end
          if (cmd_code == 3'd2 || cmd_code == 3'd3) begin
            n_col++;
            check(xfer_ready == 1'b1, "R8", "column without ready", xfer_ready, 1);
            check(xfer_go == 1'b1 && xfer_wr == (cmd_code == 3'd3), "R8", "xfer strobes",
                  {xfer_go, xfer_wr}, {1'b1, cmd_code == 3'd3});
          end else if (xfer_go) begin
            check(0, "R8", "xfer_go on non-column", xfer_go, 0);
          end
        end else if (xfer_go) begin
          check(0, "R8", "xfer_go without command", xfer_go, 0);
        end
      end
    end
  end

  // stuttering ready during the random phase
  always @(negedge clk) if (rand_phase) xfer_ready <= ($urandom % 4) != 0;

  task automatic push_req(bit wr, int rank, int bank, int row, int col);
    req_t r;
    @(negedge clk);
    if (req_full) begin
      req_push = 0;
      n_drop++;
    end else begin
      r.wr = wr; r.rank = 1'(rank); r.bank = 3'(bank); r.row = 14'(row); r.col = 11'(col);
      req_wr = wr; req_rank = r.rank; req_bank = r.bank; req_row = r.row; req_col = r.col;
      req_push = 1;
      req_q.push_back(r);
      n_acc++;
    end
  endtask

  task automatic idle(int n);
    @(negedge clk); req_push = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    idle(1);
    while (req_q.size() != 0 || exp_q.size() != 0) @(negedge clk);
    repeat (RFC + 4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=drained");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    check(cmd_valid == 0 && xfer_go == 0 && req_full == 0, "R10", "reset outputs",
          {cmd_valid, xfer_go, req_full}, 0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    check(cmd_valid == 0, "R10", "idle after reset", cmd_valid, 0);

    // R3: three accesses to one row; R4: then a different row
    push_req(0, 0, 0, 5, 10);
    push_req(1, 0, 0, 5, 11);
    push_req(0, 0, 0, 5, 12);
    push_req(1, 0, 0, 9, 13);
    drain();

    // R5 / R6: more distinct banks than table slots
    push_req(0, 0, 1, 1, 1);
    push_req(0, 0, 2, 2, 2);
    push_req(1, 0, 3, 3, 3);
    push_req(0, 1, 4, 4, 4);
    push_req(1, 0, 0, 9, 5);
    push_req(0, 1, 7, 6, 6);
    drain();
    check(n_evict >= 2, "R6", "evictions seen", n_evict, 2);

    // R1: fill the queue while the data path stalls
    @(negedge clk); xfer_ready = 0;
    n_drop = 0;
    for (int i = 0; i < DEPTH + 6; i++) push_req(i[0], i % 2, i % 5, i % 3, i);
    idle(1); #1;
    check(req_full == 1'b1, "R1", "req_full after overfill", req_full, 1);
    check(n_drop == 6, "R1", "dropped pushes", n_drop, 6);
    @(negedge clk); xfer_ready = 1;
    drain();

    // random mix spanning several refresh intervals
    rand_phase = 1;
    for (int i = 0; i < 500; i++) begin
      push_req($urandom % 2, $urandom % 2, $urandom % 4, $urandom % 3, $urandom % 2048);
      if ($urandom % 3 == 0) idle($urandom % 12);
    end
    idle(1);
    rand_phase = 0;
    @(negedge clk); xfer_ready = 1;
    drain();
    while (cyc < 3 * REFI + 400) @(negedge clk);
    repeat (RFC + 4) @(negedge clk);

    check(n_col == n_acc, "R1", "column commands vs accepted", n_col, n_acc);
    check(n_ref >= 3, "R9", "refreshes seen", n_ref, 3);
    check(n_hit > 0, "R3", "row hits seen", n_hit, 1);
    check(n_conf > 0, "R4", "row conflicts seen", n_conf, 1);
    check(exp_q.size() == 0 && req_q.size() == 0, "R2", "leftover expectations",
          exp_q.size() + req_q.size(), 0);
    finish_run();
  end
endmodule